// File: doc/BRIEF.md
# Learning-Based DRAM Command Scheduler

This block chooses one DRAM command per decision step from a fixed set of seven candidate actions. It does not follow a fixed priority. It keeps a table of estimated long-term values, indexed by a compressed view of the controller's state and by the action. In each step it issues the legal action whose stored value is highest. Commands that move data earn a reward, and the table is refined online with a fixed-point temporal-difference rule, so the scheduler comes to prefer the commands that lead to data transfers soon after.

The surrounding controller supplies six queue and row-buffer counters and a legality mask, and raises a step strobe when it wants a decision. That controller does all timing checking, so any command that would break a DRAM timing rule simply arrives with its mask bit cleared. Each counter is reduced to a 2-bit code, and the codes are folded into a table index. The chosen command appears one cycle after the step strobe, together with a valid pulse. The value update for the previous decision is computed in the step cycle and committed to the table one cycle later. A forwarding path makes that pending value visible to any read in the meantime.

Top module: `rl_cmd_sched`

## Requirements
- R1: After reset, act_o is the idle code 6, act_valid_o is 0, and every table value is 0. So the first decision with every action legal is action 0.
- R2: act_valid_o is 1 in exactly the cycles that follow a cycle with step_i high. act_o changes only in those cycles and holds its value otherwise.
- R3: A chosen action always has its legal_i bit set, except the idle action (code 6), which is always legal. An all-zero mask therefore yields code 6.
- R4: When several legal actions share the highest value, the one with the lowest code wins.
- R5: The chosen action is the legal action with the highest stored value for the current state index.
- R6: The reward is REWARD (64, which is 1.0 with 6 fractional bits) for write (code 1), read for a load miss (code 2) and read for a store miss (code 3). It is 0 for activate (0), precharge with requests pending (4), preemptive precharge (5) and idle (6).
- R7: On every step after the first, the value V of the previous (state, action) pair becomes V + ((r + N - (N >>> GAMMA_SH)) - V) >>> ALPHA_SH. Here r is the reward of that previous action and N is the value of the action just chosen in the current state. The shifts are arithmetic, with defaults GAMMA_SH=2 and ALPHA_SH=1.
- R8: An updated value saturates to the signed VAL_W range (-128..127 by default) and never wraps.
- R9: Each 4-bit counter maps to a 2-bit code: 0 gives 0, 1 gives 1, 2 or 3 give 2, and 4 or more give 3. Counters with the same code select the same table entries.
- R10: Counter k (bits [4k+3:4k] of attr_i, k = 0..5) places its code at bits [2k+1:2k] of a 12-bit vector Q. The table index is Q[5:0] XOR Q[11:6].
- R11: A decision taken in the cycle right after another decision sees the value written by that earlier decision, even though the table write is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Request for a decision in this cycle |
| attr_i | input | 24 | Six 4-bit state counters: read queue, write queue, load misses, writes pending to the open row, reorder-buffer heads waiting on the row, relative age order |
| legal_i | input | 7 | Per-action legality mask from timing checks, bit n for action code n |
| act_o | output | 3 | Chosen action code |
| act_valid_o | output | 1 | Pulse marking a new decision on act_o |

## Verification
The bench targets the cycle right after a learning step. A design without forwarding would read a stale zero there and fall back to activate instead of the read it had just been rewarded for. It drives one state/action pair upward until the value would pass 127. A wrapping adder would then turn that value negative and lose to an untouched action. The bench also probes counter values on each side of a code boundary, two distinct counter vectors that fold to the same index, ties, an empty mask, and a precharge that must earn nothing. Each of these would pick a different command if quantization, folding, tie order or reward assignment were wrong. A long pseudo-random run compares every decision against an independent model of the value table.

// File: rtl/rl_sched_pkg.sv
`timescale 1ns/1ps
package rl_sched_pkg;

    localparam int NUM_CMD = 7;
    localparam int CMD_W   = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_ACT      = 3'd0,
        CMD_WR       = 3'd1,
        CMD_RD_LOAD  = 3'd2,
        CMD_RD_STORE = 3'd3,
        CMD_PRE_PEND = 3'd4,
        CMD_PRE_SPEC = 3'd5,
        CMD_NOP      = 3'd6
    } cmd_e;

    // Data-moving commands are the only ones that earn a reward.
    function automatic logic moves_data(input logic [CMD_W-1:0] c);
        return (c == CMD_WR) || (c == CMD_RD_LOAD) || (c == CMD_RD_STORE);
    endfunction

endpackage

// File: rtl/rl_state_index.sv
`timescale 1ns/1ps
// Quantizes each counter to a 2-bit code and XOR-folds the codes to an index.
// CNT_W must be at least 3 so that the "4 or more" threshold exists.
module rl_state_index #(
    parameter int NUM_ATTR = 6,
    parameter int CNT_W    = 4,
    parameter int IDX_W    = 6
) (
    input  logic [NUM_ATTR*CNT_W-1:0] attr_i,
    output logic [IDX_W-1:0]          idx_o
);
    localparam int QV_W   = 2 * NUM_ATTR;
    localparam int CHUNKS = (QV_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = CHUNKS * IDX_W;

    logic [PAD_W-1:0] qv;

    for (genvar g = 0; g < NUM_ATTR; g++) begin : g_quant
        logic [CNT_W-1:0] cnt;
        logic [1:0]       code;
        assign cnt = attr_i[g*CNT_W +: CNT_W];
        always_comb begin
            if (cnt == '0)                 code = 2'd0;
            else if (cnt == CNT_W'(1))     code = 2'd1;
            else if (cnt < CNT_W'(4))      code = 2'd2;
            else                           code = 2'd3;
        end
        assign qv[2*g +: 2] = code;
    end

    if (PAD_W > QV_W) begin : g_pad
        assign qv[PAD_W-1:QV_W] = '0;
    end

    always_comb begin
        logic [IDX_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < CHUNKS; k++) begin
            acc = acc ^ qv[k*IDX_W +: IDX_W];
        end
        idx_o = acc;
    end

endmodule

// File: rtl/rl_value_store.sv
`timescale 1ns/1ps
// Value table: one full-row read port, one single-entry read port, one write
// port. Both reads forward the pending write so a committed value is never
// missed while it sits in the write register.
module rl_value_store #(
    parameter int NUM_ACT = 7,
    parameter int VAL_W   = 8,
    parameter int IDX_W   = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             rd_idx,
    output logic [NUM_ACT*VAL_W-1:0]     rd_row,
    input  logic [IDX_W-1:0]             pr_idx,
    input  logic [$clog2(NUM_ACT)-1:0]   pr_act,
    output logic [VAL_W-1:0]             pr_val,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [$clog2(NUM_ACT)-1:0]   wr_act,
    input  logic [VAL_W-1:0]             wr_val
);
    localparam int STATES = 1 << IDX_W;
    localparam int ACT_W  = $clog2(NUM_ACT);

    logic [VAL_W-1:0] mem_q [STATES][NUM_ACT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STATES; i++) begin
                for (int j = 0; j < NUM_ACT; j++) begin
                    mem_q[i][j] <= '0;
                end
            end
        end else if (wr_en) begin
            mem_q[wr_idx][wr_act] <= wr_val;
        end
    end

    for (genvar a = 0; a < NUM_ACT; a++) begin : g_row
        logic hit;
        assign hit = wr_en && (wr_idx == rd_idx) && (wr_act == ACT_W'(a));
        assign rd_row[a*VAL_W +: VAL_W] = hit ? wr_val : mem_q[rd_idx][a];
    end

    logic pr_hit;
    assign pr_hit = wr_en && (wr_idx == pr_idx) && (wr_act == pr_act);
    assign pr_val = pr_hit ? wr_val : mem_q[pr_idx][pr_act];

endmodule

// File: rtl/rl_argmax.sv
`timescale 1ns/1ps
// Picks the legal entry with the largest signed value; ties keep the lower code.
module rl_argmax #(
    parameter int NUM_ACT = 7,
    parameter int VAL_W   = 8
) (
    input  logic [NUM_ACT*VAL_W-1:0]   vals_i,
    input  logic [NUM_ACT-1:0]         legal_i,
    output logic [$clog2(NUM_ACT)-1:0] pick_o
);
    localparam int ACT_W = $clog2(NUM_ACT);

    always_comb begin
        logic                    found;
        logic signed [VAL_W-1:0] best_v;
        logic signed [VAL_W-1:0] v;
        found  = 1'b0;
        best_v = '0;
        pick_o = '0;
        for (int a = 0; a < NUM_ACT; a++) begin
            v = vals_i[a*VAL_W +: VAL_W];
            if (legal_i[a] && (!found || (v > best_v))) begin
                found  = 1'b1;
                best_v = v;
                pick_o = ACT_W'(a);
            end
        end
    end

endmodule

// File: rtl/rl_td_update.sv
`timescale 1ns/1ps
// Fixed-point temporal-difference step with shift-based rates and saturation.
module rl_td_update #(
    parameter int VAL_W    = 8,
    parameter int REWARD   = 64,
    parameter int ALPHA_SH = 1,
    parameter int GAMMA_SH = 2
) (
    input  logic [VAL_W-1:0] old_i,
    input  logic [VAL_W-1:0] next_i,
    input  logic             data_i,
    output logic [VAL_W-1:0] new_o
);
    localparam int EXT_W = VAL_W + 4;
    localparam logic signed [EXT_W-1:0] MAX_X = EXT_W'((2 ** (VAL_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] MIN_X = -MAX_X - EXT_W'(1);

    logic signed [EXT_W-1:0] old_x, nxt_x, rew, disc, diff, sum;

    always_comb begin
        old_x = {{(EXT_W-VAL_W){old_i[VAL_W-1]}}, old_i};
        nxt_x = {{(EXT_W-VAL_W){next_i[VAL_W-1]}}, next_i};
        rew   = data_i ? EXT_W'(REWARD) : '0;
        disc  = nxt_x - (nxt_x >>> GAMMA_SH);
        diff  = rew + disc - old_x;
        sum   = old_x + (diff >>> ALPHA_SH);
        if (sum > MAX_X)      new_o = MAX_X[VAL_W-1:0];
        else if (sum < MIN_X) new_o = MIN_X[VAL_W-1:0];
        else                  new_o = sum[VAL_W-1:0];
    end

endmodule

// File: rtl/rl_cmd_sched.sv
`timescale 1ns/1ps
module rl_cmd_sched
    import rl_sched_pkg::*;
#(
    parameter int NUM_ATTR = 6,
    parameter int CNT_W    = 4,
    parameter int IDX_W    = 6,
    parameter int VAL_W    = 8,
    parameter int REWARD   = 64,
    parameter int ALPHA_SH = 1,
    parameter int GAMMA_SH = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_i,
    input  logic [NUM_ATTR*CNT_W-1:0] attr_i,
    input  logic [NUM_CMD-1:0]        legal_i,
    output logic [CMD_W-1:0]          act_o,
    output logic                      act_valid_o
);
    typedef struct packed {
        logic [CMD_W-1:0] act;
        logic             valid;
        logic             prev_valid;
        logic [IDX_W-1:0] prev_idx;
        logic [CMD_W-1:0] prev_act;
        logic             wr_valid;
        logic [IDX_W-1:0] wr_idx;
        logic [CMD_W-1:0] wr_act;
        logic [VAL_W-1:0] wr_val;
    } ctl_t;

    localparam ctl_t CTL_RST = '{act: CMD_NOP, default: '0};

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0]         cur_idx;
    logic [NUM_CMD*VAL_W-1:0] row_w;
    logic [NUM_CMD-1:0]       legal_eff;
    logic [CMD_W-1:0]         pick_w;
    logic [VAL_W-1:0]         next_val;
    logic [VAL_W-1:0]         prev_val;
    logic [VAL_W-1:0]         upd_val;
    logic                     wr_pend_w;

    rl_state_index #(
        .NUM_ATTR (NUM_ATTR),
        .CNT_W    (CNT_W),
        .IDX_W    (IDX_W)
    ) u_index (
        .attr_i (attr_i),
        .idx_o  (cur_idx)
    );

    rl_value_store #(
        .NUM_ACT (NUM_CMD),
        .VAL_W   (VAL_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (cur_idx),
        .rd_row (row_w),
        .pr_idx (ctl_q.prev_idx),
        .pr_act (ctl_q.prev_act),
        .pr_val (prev_val),
        .wr_en  (ctl_q.wr_valid),
        .wr_idx (ctl_q.wr_idx),
        .wr_act (ctl_q.wr_act),
        .wr_val (ctl_q.wr_val)
    );

    // The idle command is never blocked.
    assign legal_eff = legal_i | (NUM_CMD'(1) << CMD_NOP);

    rl_argmax #(
        .NUM_ACT (NUM_CMD),
        .VAL_W   (VAL_W)
    ) u_argmax (
        .vals_i  (row_w),
        .legal_i (legal_eff),
        .pick_o  (pick_w)
    );

    assign next_val = row_w[pick_w*VAL_W +: VAL_W];

    rl_td_update #(
        .VAL_W    (VAL_W),
        .REWARD   (REWARD),
        .ALPHA_SH (ALPHA_SH),
        .GAMMA_SH (GAMMA_SH)
    ) u_td (
        .old_i  (prev_val),
        .next_i (next_val),
        .data_i (moves_data(ctl_q.prev_act)),
        .new_o  (upd_val)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.valid    = 1'b0;
        ctl_d.wr_valid = 1'b0;
        if (step_i) begin
            ctl_d.act   = pick_w;
            ctl_d.valid = 1'b1;
            if (ctl_q.prev_valid) begin
                ctl_d.wr_valid = 1'b1;
                ctl_d.wr_idx   = ctl_q.prev_idx;
                ctl_d.wr_act   = ctl_q.prev_act;
                ctl_d.wr_val   = upd_val;
            end
            ctl_d.prev_valid = 1'b1;
            ctl_d.prev_idx   = cur_idx;
            ctl_d.prev_act   = pick_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign act_o       = ctl_q.act;
    assign act_valid_o = ctl_q.valid;
    assign wr_pend_w   = ctl_q.wr_valid;

endmodule

// File: rtl/rl_cmd_sched_chk.sv
`timescale 1ns/1ps
module rl_cmd_sched_chk
    import rl_sched_pkg::*;
#(
    parameter int VAL_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      step_i,
    input logic [NUM_CMD-1:0]        legal_i,
    input logic [CMD_W-1:0]          act_o,
    input logic                      act_valid_o,
    input logic [CMD_W-1:0]          pick,
    input logic [NUM_CMD*VAL_W-1:0]  row,
    input logic [NUM_CMD-1:0]        legal_eff,
    input logic                      wr_pend
);
    logic [NUM_CMD-1:0] leg_q;
    logic               pick_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) leg_q <= '0;
        else        leg_q <= legal_i;
    end

    always_comb begin
        logic signed [VAL_W-1:0] va, vp;
        vp      = row[pick*VAL_W +: VAL_W];
        pick_ok = legal_eff[pick];
        for (int a = 0; a < NUM_CMD; a++) begin
            va = row[a*VAL_W +: VAL_W];
            if (legal_eff[a] && ((va > vp) || ((va == vp) && (CMD_W'(a) < pick))))
                pick_ok = 1'b0;
        end
    end

    // R2
    valid_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> act_valid_o);

    // R2
    quiet_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> (!act_valid_o && $stable(act_o)));

    // R3
    only_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid_o |-> ((act_o == CMD_NOP) || leg_q[act_o]));

    // R5
    best_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> pick_ok);

    // R7
    write_follows_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |-> $past(step_i));

endmodule

bind rl_cmd_sched rl_cmd_sched_chk #(.VAL_W(VAL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .legal_i     (legal_i),
    .act_o       (act_o),
    .act_valid_o (act_valid_o),
    .pick        (pick_w),
    .row         (row_w),
    .legal_eff   (legal_eff),
    .wr_pend     (wr_pend_w)
);

// File: tb/rl_cmd_sched_test.sv
`timescale 1ns/1ps
module rl_cmd_sched_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic [23:0] attr_i = '0;
    logic [6:0]  legal_i = '0;
    logic [2:0]  act_o;
    logic        act_valid_o;

    int n_chk  = 0;
    int n_fail = 0;

    int mq [64][7];
    bit m_prev_valid = 1'b0;
    int m_prev_s = 0;
    int m_prev_a = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rl_cmd_sched uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_i),
        .attr_i      (attr_i),
        .legal_i     (legal_i),
        .act_o       (act_o),
        .act_valid_o (act_valid_o)
    );

    function automatic logic [23:0] mk(int c0, int c1, int c2, int c3, int c4, int c5);
        return {c5[3:0], c4[3:0], c3[3:0], c2[3:0], c1[3:0], c0[3:0]};
    endfunction

    // R9 / R10: quantize and fold, written from the requirement text.
    function automatic int idx_of(logic [23:0] a);
        int qv = 0;
        for (int k = 0; k < 6; k++) begin
            int c = int'(a[k*4 +: 4]);
            int q = (c == 0) ? 0 : (c == 1) ? 1 : (c < 4) ? 2 : 3;
            qv = qv | (q << (2*k));
        end
        return (qv & 63) ^ ((qv >> 6) & 63);
    endfunction

    function automatic int model_pick(int s, logic [6:0] m);
        int best = -1;
        int bv = 0;
        for (int a = 0; a < 7; a++) begin
            if ((m[a] || a == 6) && (best < 0 || mq[s][a] > bv)) begin
                best = a;
                bv = mq[s][a];
            end
        end
        return best;
    endfunction

    function automatic int model_upd(int old, int r, int nxt);
        int disc = nxt - (nxt >>> 2);
        int d = r + disc - old;
        int n = old + (d >>> 1);
        if (n > 127) n = 127;
        if (n < -128) n = -128;
        return n;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_step(input logic [23:0] attrs, input logic [6:0] mask,
                           input int want, input string req);
        int s, e, r;
        s = idx_of(attrs);
        e = model_pick(s, mask);
        if (m_prev_valid) begin
            r = (m_prev_a >= 1 && m_prev_a <= 3) ? 64 : 0;
            mq[m_prev_s][m_prev_a] = model_upd(mq[m_prev_s][m_prev_a], r, mq[s][e]);
        end
        m_prev_valid = 1'b1;
        m_prev_s = s;
        m_prev_a = e;
        attr_i  = attrs;
        legal_i = mask;
        step_i  = 1'b1;
        @(negedge clk);
        check(act_valid_o === 1'b1, "R2 strobe", int'(act_valid_o), 1);
        check(int'(act_o) == e, {req, " model"}, int'(act_o), e);
        if (want >= 0) check(int'(act_o) == want, req, int'(act_o), want);
    endtask

    task automatic idle(input int n);
        logic [2:0] held;
        step_i = 1'b0;
        held = act_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(act_valid_o === 1'b0, "R2 no strobe", int'(act_valid_o), 0);
            check(act_o == held, "R2 hold", int'(act_o), int'(held));
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step_i = 1'b0;
        repeat (3) @(negedge clk);
        check(act_valid_o === 1'b0, "R1 valid in reset", int'(act_valid_o), 0);
        check(act_o == 3'd6, "R1 idle code in reset", int'(act_o), 6);
        rst_n = 1'b1;
        @(negedge clk);
        check(act_valid_o === 1'b0, "R1 valid after reset", int'(act_valid_o), 0);
        check(act_o == 3'd6, "R1 idle code after reset", int'(act_o), 6);
    endtask

    task automatic t_tie_mask();
        do_step(mk(0,0,0,0,0,0), 7'h7F, 0, "R1 R4 zero table tie");
        do_step(mk(0,0,0,0,0,0), 7'h00, 6, "R3 empty mask gives idle");
        do_step(mk(0,0,0,0,0,0), 7'b0001000, 3, "R3 single legal");
        do_step(mk(0,0,0,0,0,0), 7'b0100000, 5, "R3 single legal precharge");
    endtask

    task automatic t_learn();
        do_step(mk(1,0,0,0,0,0), 7'b0000100, 2, "R5 seed read");
        do_step(mk(0,1,0,0,0,0), 7'b0000000, 6, "R3 filler");
        do_step(mk(1,0,0,0,0,0), 7'b0000101, 2, "R11 R5 bypassed learned read");
        idle(2);
        do_step(mk(1,0,0,0,0,0), 7'b0000101, 2, "R5 learned read after gap");
        // zero reward for precharge
        do_step(mk(0,0,1,0,0,0), 7'b0010000, 4, "R6 seed precharge");
        do_step(mk(0,2,0,0,0,0), 7'b0000000, 6, "R6 filler");
        do_step(mk(0,0,1,0,0,0), 7'b0010001, 0, "R6 precharge earns nothing");
        // write is rewarded
        do_step(mk(0,0,2,0,0,0), 7'b0000010, 1, "R6 seed write");
        do_step(mk(1,1,0,0,0,0), 7'b0000000, 6, "R6 filler");
        do_step(mk(0,0,2,0,0,0), 7'b0000011, 1, "R6 write rewarded");
    endtask

    task automatic t_quant();
        do_step(mk(0,0,5,0,0,0), 7'b0000100, 2, "R9 seed");
        do_step(mk(0,1,1,0,0,0), 7'b0000000, 6, "R9 filler");
        do_step(mk(0,0,15,0,0,0), 7'b0000101, 2, "R9 same code 5 and 15");
        do_step(mk(0,0,3,0,0,0), 7'b0000101, 0, "R9 code 3 differs from 5");
    endtask

    task automatic t_fold();
        do_step(mk(0,0,0,4,0,0), 7'b0001000, 3, "R10 seed");
        do_step(mk(1,0,1,0,0,0), 7'b0000000, 6, "R10 filler");
        do_step(mk(4,0,0,0,0,0), 7'b0001001, 3, "R10 folded alias shares value");
    endtask

    task automatic t_sat();
        for (int i = 0; i < 8; i++)
            do_step(mk(0,0,0,0,4,0), 7'b0001000, 3, "R8 R11 drive upward");
        do_step(mk(0,0,0,0,4,0), 7'b0001001, 3, "R8 saturated not wrapped");
    endtask

    task automatic t_random();
        logic [15:0] lf = 16'hACE1;
        logic [23:0] at;
        for (int i = 0; i < 150; i++) begin
            at = '0;
            for (int k = 0; k < 6; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                at[k*4 +: 4] = {1'b0, lf[2:0]};
            end
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_step(at, lf[6:0], -1, "R7");
            if (i % 7 == 6) idle(1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog R2: run did not finish, actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < 64; s++)
            for (int a = 0; a < 7; a++)
                mq[s][a] = 0;
        @(negedge clk);
        t_reset();
        t_tie_mask();
        t_learn();
        t_quant();
        t_fold();
        t_sat();
        t_random();
        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule